// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two signed two's-complement operands, one digit per clock. A start strobe captures both operands and the block then scans the second operand (the multiplier) two bits at a time. Each step reads a group of three bits that overlaps the previous group by one bit and turns it into a signed digit in the range -2 to +2. The digit picks zero, the first operand (the multiplicand), or twice the multiplicand. Twice the multiplicand is a one-bit left shift, and a negative digit is applied as the bitwise inverse plus a carry-in. The addend is sign-extended to the full product width before it is added to an accumulator.

A 16-bit multiplier gives eight digits, so a product is ready eight clock cycles after start is accepted. The multiplicand is shifted left two places after every step, so each digit carries a weight of four times the previous one. Busy stays high while the steps run. Done pulses for one cycle when the product is final, and the product then holds until the next operation starts.

Top module: `booth4_mul`

## Requirements
- R1: Digit j is formed from multiplier bits {b[2j+1], b[2j], b[2j-1]}, with b[-1] = 0. The groups 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1.
- R2: The multiple 2A is the multiplicand shifted left by one bit. Digit j is scaled by 4^j through a two-bit left shift of the multiplicand after each step.
- R3: A negative digit adds the bitwise inverse of the selected multiple, with a carry-in of 1, to the 32-bit accumulator. Every addend is sign-extended to 32 bits.
- R4: When done is high, the 32-bit product equals the exact signed product of the two captured operands.
- R5: Done goes high exactly 8 clock cycles after the edge that accepts start, and it stays high for exactly one cycle.
- R6: Busy is high from the cycle after start is accepted until done is raised. Busy is low whenever done is high.
- R7: A start strobe while busy is high is ignored: the operation in progress finishes on time with its original operands.
- R8: While idle and with start low, the product output holds its last value, whatever the operand inputs do.
- R9: After reset, busy, done and product are all zero.
- R10: -32768 x -32768 gives +1073741824 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe that begins a multiply when the block is idle |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier, two's complement |
| busy | output | 1 | High while the digit steps are running |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 32 | Signed product |

## Verification
The bench picks multiplier patterns that exercise every three-bit group, including alternating bits and all ones. A wrong entry in the recoding table shows up as a product that is off by a shifted multiple of the multiplicand. The extreme operands -32768 and 32767, in every sign combination, expose a missing sign extension or a dropped carry-in: the product then comes out off by one or with the wrong sign. A start strobe in the middle of an operation, and operand changes while idle, would expose a block that restarts or lets the held product drift. Done is checked at every cycle of an operation, so a latency that is one cycle early or late, or a done that lasts two cycles, is caught.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  // Signed digit in [-2,2]: magnitude is zero, one or two; neg gives the sign.
  typedef struct packed {
    logic neg;
    logic two;
    logic zero;
  } bdigit_t;

  // Three overlapping multiplier bits {hi, mid, lo} -> signed digit.
  function automatic bdigit_t recode_triplet(input logic [2:0] t);
    bdigit_t d;
    case (t)
      3'b000:  d = '{neg: 1'b0, two: 1'b0, zero: 1'b1};
      3'b001:  d = '{neg: 1'b0, two: 1'b0, zero: 1'b0};
      3'b010:  d = '{neg: 1'b0, two: 1'b0, zero: 1'b0};
      3'b011:  d = '{neg: 1'b0, two: 1'b1, zero: 1'b0};
      3'b100:  d = '{neg: 1'b1, two: 1'b1, zero: 1'b0};
      3'b101:  d = '{neg: 1'b1, two: 1'b0, zero: 1'b0};
      3'b110:  d = '{neg: 1'b1, two: 1'b0, zero: 1'b0};
      default: d = '{neg: 1'b0, two: 1'b0, zero: 1'b1};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth4_recode.sv
module booth4_recode
  import booth4_pkg::*;
(
  input  logic [2:0] trip,
  output bdigit_t    dig
);
  always_comb dig = recode_triplet(trip);
endmodule

// File: rtl/booth4_ppgen.sv
module booth4_ppgen
  import booth4_pkg::*;
#(
  parameter int PW = 32
) (
  input  bdigit_t          dig,
  input  logic [PW-1:0]    mcand,
  output logic [PW-1:0]    addend,
  output logic             cin
);
  logic [PW-1:0] mult;

  always_comb begin
    if (dig.zero)      mult = '0;
    else if (dig.two)  mult = {mcand[PW-2:0], 1'b0};
    else               mult = mcand;
    addend = dig.neg ? ~mult : mult;
    cin    = dig.neg;
  end
endmodule

// File: rtl/booth4_ctrl.sv
module booth4_ctrl #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic step,
  output logic last
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0] cnt_q;

  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= last;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (last) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
  import booth4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic            busy,
  output logic            done,
  output logic [2*W-1:0]  product
);
  localparam int PW    = 2 * W;
  localparam int STEPS = W / 2;

  logic [PW-1:0] mcand_q;
  logic [W:0]    mplr_q;
  logic [PW-1:0] acc_q;

  // Named internal events for the checker.
  logic          load_fire;
  logic          step_fire;
  logic          last_fire;
  bdigit_t       dig;
  logic [2:0]    dig_bits;
  logic [PW-1:0] addend;
  logic          cin;

  booth4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done),
    .load (load_fire),
    .step (step_fire),
    .last (last_fire)
  );

  booth4_recode u_rec (
    .trip(mplr_q[2:0]),
    .dig (dig)
  );

  booth4_ppgen #(.PW(PW)) u_pp (
    .dig   (dig),
    .mcand (mcand_q),
    .addend(addend),
    .cin   (cin)
  );

  assign dig_bits = dig;
  assign product  = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      mplr_q  <= '0;
      acc_q   <= '0;
    end else if (load_fire) begin
      mcand_q <= {{W{op_a[W-1]}}, op_a};
      mplr_q  <= {op_b, 1'b0};
      acc_q   <= '0;
    end else if (step_fire) begin
      acc_q   <= acc_q + addend + {{(PW-1){1'b0}}, cin};
      mcand_q <= {mcand_q[PW-3:0], 2'b00};
      mplr_q  <= {{2{mplr_q[W]}}, mplr_q[W:2]};
    end
  end
endmodule

// File: rtl/booth4_mul_chk.sv
module booth4_mul_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product,
  input logic           load_fire,
  input logic [2:0]     dig_bits
);
  localparam int STEPS = W / 2;
  localparam int LW    = $clog2(STEPS + 2);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       lat_q <= '0;
    else if (load_fire)               lat_q <= LW'(1);
    else if (lat_q != '0 && lat_q <= LW'(STEPS)) lat_q <= lat_q + 1'b1;
  end

  // dig_bits = {neg, two, zero}
  p_digit_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(dig_bits[0] && (dig_bits[1] || dig_bits[2])));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LW'(STEPS + 1)));

  p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind booth4_mul booth4_mul_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .product  (product),
  .load_fire(load_fire),
  .dig_bits (dig_bits)
);

// File: tb/booth4_mul_test.sv
module booth4_mul_test;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          busy;
  logic          done;
  logic [2*W-1:0] product;

  int total = 0;
  int bad   = 0;
  logic [2*W-1:0] expq[$];
  logic [2*W-1:0] last_exp = '0;

  always #5 clk = ~clk;

  booth4_mul #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint pr = sa * sb;
    return pr[2*W-1:0];
  endfunction

  // Monitor: compare each result against the scoreboard as done appears.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4 unexpected done", longint'(product), 0);
      end else begin
        logic [2*W-1:0] e;
        e = expq.pop_front();
        check(product == e, "R4 product", longint'($signed(product)), longint'($signed(e)));
      end
    end
  end

  // Driver: push expected, pulse start, watch busy/done timing (R5, R6).
  // poke=1 raises start again with other operands mid-run (R7).
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    @(negedge clk);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    last_exp = ref_mul(a, b);
    expq.push_back(last_exp);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (poke && k == 3) begin
        op_a = ~a; op_b = b ^ 16'h1234; start = 1'b1;
      end
      if (poke && k == 4) start = 1'b0;
      if (k < 9) begin
        check(busy == 1'b1, "R6 busy during run", longint'(busy), 1);
        check(done == 1'b0, "R5 done early", longint'(done), 0);
      end else begin
        check(done == 1'b1, "R5 done at cycle 8", longint'(done), 1);
        check(busy == 1'b0, "R6 busy low with done", longint'(busy), 0);
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", longint'(done), 0);
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9 busy reset", longint'(busy), 0);
    check(done == 1'b0, "R9 done reset", longint'(done), 0);
    check(product == '0, "R9 product reset", longint'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(16'd3, 16'd5, 1'b0);                 // R4 small positive
    run_op(-16'sd7, 16'd6, 1'b0);               // R3 negative multiplicand
    run_op(16'd1234, -16'sd4321, 1'b0);         // R3 negative multiplier
    run_op(16'd1, 16'h5A97, 1'b0);              // R1 mixed triplets, product = b
    run_op(-16'sd3, 16'h6B3C, 1'b0);            // R1 remaining triplets
    run_op(16'd1, 16'h5555, 1'b0);              // R1 alternating bits: +1 digits
    run_op(16'd77, 16'hAAAA, 1'b0);             // R1 alternating bits: -1/-2 digits
    run_op(16'hFFFF, 16'hFFFF, 1'b0);           // R1 all ones: -1 x -1
    run_op(16'd300, 16'h6666, 1'b0);            // R2 +2 digits
    run_op(16'h7FFF, 16'h7FFF, 1'b0);           // R4 max positive
    run_op(16'h8000, 16'h7FFF, 1'b0);           // R3 extreme sign mix
    run_op(16'h8000, 16'h8000, 1'b0);           // R10 -32768 squared
    check(product == 32'd1073741824, "R10 min squared", longint'(product), 1073741824);
    run_op(16'd0, 16'h9ABC, 1'b0);              // R4 zero multiplicand

    // R7: start mid-run is ignored
    run_op(16'd4660, -16'sd22136, 1'b1);
    check(expq.size() == 0, "R7 no extra result", longint'(expq.size()), 0);

    // R8: product holds while idle as operands change
    op_a = 16'h1111; op_b = 16'h2222;
    repeat (4) @(negedge clk);
    op_a = 16'h8000; op_b = 16'h7FFF;
    repeat (3) @(negedge clk);
    check(product == last_exp, "R8 product held", longint'($signed(product)), longint'($signed(last_exp)));
    check(busy == 1'b0, "R8 still idle", longint'(busy), 0);

    repeat (2) @(negedge clk);
    check(expq.size() == 0, "R4 all results seen", longint'(expq.size()), 0);
    report();
    $finish;
  end
endmodule